// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Aligner

This block sits between an 8-bit processor's decode stage and a memory that answers each read with a whole line of several bytes. On a fetch request it reads the line that holds the program counter. It picks out the opcode and looks up the instruction length from that opcode, which is 1, 2 or 3 bytes. It then places the opcode and its operand bytes into fixed output slots, whatever their positions in the line.

An instruction can run past the last byte of its line. In that case the bytes already taken stay in their slots, and the aligner reads the following line. The remaining operand bytes are filled in from the start of that line. The finished packet is offered with a ready/valid handshake. The length output doubles as the program-counter increment, and the address of the next instruction is also given. A flush, used on a branch or jump, abandons any fetch in progress and restarts at a new address.

The line width `LINE_BYTES` is a power of two and at least 2. The address width is `ADDR_W`.

Top module: `fetch_align`

## Requirements
- R1: While reset is asserted and right after it is released, `pkt_valid_o` and `mem_req_o` are low.
- R2: The instruction length comes from the opcode and follows these rules, where "mode" means opcode bits [4:2]:
  - Opcode bits [1:0] = 01: length 3 for modes 011, 110 and 111; otherwise 2.
  - Bits [1:0] = 10: length 3 for modes 011 and 111; length 1 for modes 010, 100 and 110; otherwise 2.
  - Bits [1:0] = 00: length 3 for opcode 20h and for modes 011 and 111; length 1 for opcodes 00h, 40h, 60h and 80h and for modes 010 and 110; otherwise 2.
  - Bits [1:0] = 11: length 1.
- R3: The byte at the program counter appears on `pkt_opcode_o`. The byte at PC+1 appears on `pkt_op1_o` and the byte at PC+2 on `pkt_op2_o`. Operand slots beyond the instruction length read zero.
- R4: When (PC mod `LINE_BYTES`) + length ≤ `LINE_BYTES`, the packet is built from exactly one line access, and `pkt_valid_o` and `mem_req_o` are never high together.
- R5: When the instruction crosses the end of its line, exactly two line accesses are made. The second reads line index +1, wrapping modulo 2^(`ADDR_W`-log2 `LINE_BYTES`), and its leading bytes complete the packet.
- R6: `pkt_len_o` equals the instruction length (1..3), and `pc_next_o` equals PC + length modulo 2^`ADDR_W`.
- R7: While `pkt_valid_o` is high and `pkt_ready_i` is low, the packet outputs hold steady. After the handshake with no new request, `pkt_valid_o` falls.
- R8: `flush_i` takes priority over everything else. It discards any held fragment or pending packet and starts a fresh fetch at `pc_i` in the next cycle.
- R9: The first access for an instruction presents line index PC >> log2(`LINE_BYTES`) on `mem_line_o`. A response counts only in a cycle where `mem_req_o` and `mem_valid_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_req_i | input | 1 | Start a fetch at `pc_i` (taken when idle or on handshake) |
| flush_i | input | 1 | Abandon current work and fetch at `pc_i` |
| pc_i | input | ADDR_W | Byte address of the instruction to fetch |
| mem_req_o | output | 1 | Line read outstanding |
| mem_line_o | output | ADDR_W-log2(LINE_BYTES) | Line index being read |
| mem_valid_i | input | 1 | Line data valid; completes the read |
| mem_data_i | input | 8*LINE_BYTES | Line data, byte k at bits [8k+7:8k] |
| pkt_valid_o | output | 1 | Packet valid |
| pkt_ready_i | input | 1 | Downstream accepts packet |
| pkt_opcode_o | output | 8 | Opcode slot |
| pkt_op1_o | output | 8 | First operand slot |
| pkt_op2_o | output | 8 | Second operand slot |
| pkt_len_o | output | 2 | Instruction length / PC increment |
| pc_next_o | output | ADDR_W | Address of the following instruction |

## Verification
The bench drives instructions that end exactly on the last byte of a line and instructions that overrun it by one or two bytes. A design that got the boundary compare off by one would either issue a needless second read or drop an operand. It also fetches at the top of the address space, where a second line index that does not wrap would read the wrong memory. A flush is applied while the second half of a straddling instruction is still outstanding, so a stale fragment leaking into the restarted packet shows up as a wrong operand. Random downstream stalls expose packets that change or vanish before they are accepted.

// File: rtl/fetch_align_pkg.sv
package fetch_align_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_OUT    = 2'd3
  } fa_state_e;

  localparam int unsigned SLOTS = 3;
endpackage

// File: rtl/fa_len_decode.sv
module fa_len_decode (
  input  logic [7:0] op_i,
  output logic [1:0] len_o
);
  logic [2:0] mode;
  assign mode = op_i[4:2];

  always_comb begin
    len_o = 2'd1;
    unique case (op_i[1:0])
      2'b01: len_o = (mode == 3'b011 || mode == 3'b110 || mode == 3'b111) ? 2'd3 : 2'd2;
      2'b10: begin
        if (mode == 3'b011 || mode == 3'b111)                        len_o = 2'd3;
        else if (mode == 3'b010 || mode == 3'b100 || mode == 3'b110) len_o = 2'd1;
        else                                                          len_o = 2'd2;
      end
      2'b00: begin
        if (op_i == 8'h20 || mode == 3'b011 || mode == 3'b111)       len_o = 2'd3;
        else if (mode == 3'b010 || mode == 3'b110)                   len_o = 2'd1;
        else if (mode == 3'b000 && !(op_i[7] && (op_i[6] || op_i[5]))) len_o = 2'd1;
        else                                                          len_o = 2'd2;
      end
      default: len_o = 2'd1;
    endcase
  end
endmodule

// File: rtl/fa_byte_sel.sv
module fa_byte_sel #(
  parameter int unsigned LINE_BYTES = 4,
  localparam int unsigned OFF_W = $clog2(LINE_BYTES)
) (
  input  logic [LINE_BYTES*8-1:0] line_i,
  input  logic [OFF_W-1:0]        idx_i,
  output logic [7:0]              byte_o
);
  assign byte_o = line_i[idx_i*8 +: 8];
endmodule

// File: rtl/fetch_align.sv
module fetch_align
  import fetch_align_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned LINE_BYTES = 4,
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned LINE_W = ADDR_W - OFF_W,
  localparam int unsigned CNT_W  = OFF_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fetch_req_i,
  input  logic                    flush_i,
  input  logic [ADDR_W-1:0]       pc_i,
  output logic                    mem_req_o,
  output logic [LINE_W-1:0]       mem_line_o,
  input  logic                    mem_valid_i,
  input  logic [LINE_BYTES*8-1:0] mem_data_i,
  output logic                    pkt_valid_o,
  input  logic                    pkt_ready_i,
  output logic [7:0]              pkt_opcode_o,
  output logic [7:0]              pkt_op1_o,
  output logic [7:0]              pkt_op2_o,
  output logic [1:0]              pkt_len_o,
  output logic [ADDR_W-1:0]       pc_next_o
);
  fa_state_e                state_q;
  logic [ADDR_W-1:0]        pc_q;
  logic [SLOTS-1:0][7:0]    slot_q;
  logic [1:0]               len_q;
  logic [1:0]               have_q;

  logic [OFF_W-1:0]         off;
  logic [CNT_W-1:0]         avail;
  logic [OFF_W-1:0]         sel_idx  [SLOTS];
  logic [7:0]               sel_byte [SLOTS];
  logic [1:0]               dec_len;
  logic [1:0]               take;
  logic                     straddle;

  assign off      = pc_q[OFF_W-1:0];
  assign avail    = CNT_W'(LINE_BYTES) - CNT_W'(off);
  assign straddle = int'(dec_len) > int'(avail);
  assign take     = straddle ? 2'(avail) : dec_len;

  // Slot j: first line starts at the PC offset, second line continues at byte 0.
  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    assign sel_idx[j] = (state_q == ST_SECOND) ? OFF_W'(j) - OFF_W'(have_q)
                                               : off + OFF_W'(j);
    fa_byte_sel #(.LINE_BYTES(LINE_BYTES)) u_sel (
      .line_i (mem_data_i),
      .idx_i  (sel_idx[j]),
      .byte_o (sel_byte[j])
    );
  end

  fa_len_decode u_dec (
    .op_i  (sel_byte[0]),
    .len_o (dec_len)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      slot_q  <= '0;
      len_q   <= '0;
      have_q  <= '0;
    end else if (flush_i) begin
      state_q <= ST_FIRST;
      pc_q    <= pc_i;
      slot_q  <= '0;
      len_q   <= '0;
      have_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (fetch_req_i) begin
          state_q <= ST_FIRST;
          pc_q    <= pc_i;
          slot_q  <= '0;
        end
        ST_FIRST: if (mem_valid_i) begin
          len_q  <= dec_len;
          have_q <= take;
          for (int j = 0; j < SLOTS; j++)
            if (2'(j) < take) slot_q[j] <= sel_byte[j];
          state_q <= straddle ? ST_SECOND : ST_OUT;
        end
        ST_SECOND: if (mem_valid_i) begin
          for (int j = 0; j < SLOTS; j++)
            if (2'(j) >= have_q && 2'(j) < len_q) slot_q[j] <= sel_byte[j];
          state_q <= ST_OUT;
        end
        ST_OUT: if (pkt_ready_i) begin
          if (fetch_req_i) begin
            state_q <= ST_FIRST;
            pc_q    <= pc_i;
            slot_q  <= '0;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o    = (state_q == ST_FIRST) || (state_q == ST_SECOND);
  assign mem_line_o   = pc_q[ADDR_W-1:OFF_W] + LINE_W'(state_q == ST_SECOND);
  assign pkt_valid_o  = (state_q == ST_OUT);
  assign pkt_opcode_o = slot_q[0];
  assign pkt_op1_o    = slot_q[1];
  assign pkt_op2_o    = slot_q[2];
  assign pkt_len_o    = len_q;
  assign pc_next_o    = pc_q + ADDR_W'(len_q);
endmodule

// File: rtl/fetch_align_chk.sv
module fetch_align_chk #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned LINE_BYTES = 4,
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned LINE_W = ADDR_W - OFF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              mem_req_o,
  input logic [LINE_W-1:0] mem_line_o,
  input logic              mem_valid_i,
  input logic              pkt_valid_o,
  input logic              pkt_ready_i,
  input logic [7:0]        pkt_opcode_o,
  input logic [7:0]        pkt_op1_o,
  input logic [7:0]        pkt_op2_o,
  input logic [1:0]        pkt_len_o
);
  p_len_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> pkt_len_o != 2'd0);

  p_pad_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_len_o == 2'd1) |-> (pkt_op1_o == 8'h00 && pkt_op2_o == 8'h00));

  p_pad_zero2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_len_o == 2'd2) |-> pkt_op2_o == 8'h00);

  p_no_overlap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pkt_valid_o && mem_req_o));

  p_line_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i && !flush_i) |=>
      (!mem_req_o || mem_line_o == $past(mem_line_o) + LINE_W'(1)));

  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i && !flush_i) |=>
      (pkt_valid_o && $stable(pkt_opcode_o) && $stable(pkt_op1_o) &&
       $stable(pkt_op2_o) && $stable(pkt_len_o)));

  p_flush_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (mem_req_o && !pkt_valid_o));
endmodule

bind fetch_align fetch_align_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .mem_req_o    (mem_req_o),
  .mem_line_o   (mem_line_o),
  .mem_valid_i  (mem_valid_i),
  .pkt_valid_o  (pkt_valid_o),
  .pkt_ready_i  (pkt_ready_i),
  .pkt_opcode_o (pkt_opcode_o),
  .pkt_op1_o    (pkt_op1_o),
  .pkt_op2_o    (pkt_op2_o),
  .pkt_len_o    (pkt_len_o)
);

// File: tb/fetch_align_bench.sv
module fetch_align_bench;
  localparam int unsigned AW = 16;
  localparam int unsigned LB = 4;
  localparam int unsigned LW = AW - 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_req = 1'b0;
  logic          flush = 1'b0;
  logic [AW-1:0] pc = '0;
  logic          mem_req;
  logic [LW-1:0] mem_line;
  logic          mem_valid = 1'b0;
  logic [LB*8-1:0] mem_data = '0;
  logic          pkt_valid;
  logic          pkt_ready = 1'b0;
  logic [7:0]    opc, op1, op2;
  logic [1:0]    len;
  logic [AW-1:0] pc_next;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int acc_total = 0;
  logic [LW-1:0] acc_log [4];
  int lat_cnt = 0;
  logic [7:0] mem [1024];

  always #2 clk = ~clk;

  fetch_align u_fetch_align (
    .clk_i(clk), .rst_ni(rst_n), .fetch_req_i(fetch_req), .flush_i(flush), .pc_i(pc),
    .mem_req_o(mem_req), .mem_line_o(mem_line), .mem_valid_i(mem_valid), .mem_data_i(mem_data),
    .pkt_valid_o(pkt_valid), .pkt_ready_i(pkt_ready), .pkt_opcode_o(opc),
    .pkt_op1_o(op1), .pkt_op2_o(op2), .pkt_len_o(len), .pc_next_o(pc_next)
  );

  // memory model: random latency, data follows the presented line index
  always @(negedge clk) begin
    if (mem_req && lat_cnt == 0) begin
      mem_valid <= 1'b1;
      for (int k = 0; k < LB; k++) begin
        logic [AW-1:0] a;
        a = {mem_line, 2'b00} + AW'(k);
        mem_data[k*8 +: 8] <= mem[a[9:0]];
      end
      lat_cnt <= int'($urandom % 3);
    end else begin
      mem_valid <= 1'b0;
      if (mem_req && lat_cnt != 0) lat_cnt <= lat_cnt - 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && mem_req && mem_valid && !flush) begin
      acc_log[acc_total % 4] <= mem_line;
      acc_total <= acc_total + 1;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 150000) begin
    errors++; checks++;
    $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
    finish_run();
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_len(input logic [7:0] o);
    casez (o)
      8'b???01101, 8'b???11001, 8'b???11101: return 2'd3;
      8'b??????01:                           return 2'd2;
      8'b???01110, 8'b???11110:              return 2'd3;
      8'b???01010, 8'b???10010, 8'b???11010: return 2'd1;
      8'b??????10:                           return 2'd2;
      8'h20, 8'b???01100, 8'b???11100:       return 2'd3;
      8'h00, 8'h40, 8'h60, 8'h80:            return 2'd1;
      8'b???01000, 8'b???11000:              return 2'd1;
      8'b??????00:                           return 2'd2;
      default:                               return 2'd1;
    endcase
  endfunction

  function automatic logic [7:0] rd(input logic [AW-1:0] a);
    return mem[a[9:0]];
  endfunction

  task automatic wait_pkt(output bit seen);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pkt_valid) begin seen = 1; break; end
    end
  endtask

  task automatic check_pkt(input logic [AW-1:0] p, input int base, input string tag);
    logic [7:0] b0, e1, e2;
    logic [1:0] el;
    int n_acc, off;
    b0 = rd(p);
    el = ref_len(b0);
    e1 = (el >= 2) ? rd(p + 1) : 8'h00;
    e2 = (el == 3) ? rd(p + 2) : 8'h00;
    off = int'(p[1:0]);
    n_acc = (off + int'(el) > LB) ? 2 : 1;
    chk(opc == b0, {tag, " R3 opcode"}, opc, b0);
    chk(op1 == e1 && op2 == e2, {tag, " R3 operands"}, {op1, op2}, {e1, e2});
    chk(len == el, {tag, " R2 length"}, len, el);
    chk(pc_next == p + AW'(el), {tag, " R6 pc_next"}, pc_next, p + AW'(el));
    if (n_acc == 1) chk(acc_total - base == 1, {tag, " R4 single access"}, acc_total - base, 1);
    else            chk(acc_total - base == 2, {tag, " R5 two accesses"}, acc_total - base, 2);
    chk(acc_log[base % 4] == p[AW-1:2], {tag, " R9 first line"}, acc_log[base % 4], p[AW-1:2]);
    if (n_acc == 2)
      chk(acc_log[(base + 1) % 4] == p[AW-1:2] + LW'(1), {tag, " R5 next line"},
          acc_log[(base + 1) % 4], p[AW-1:2] + LW'(1));
  endtask

  task automatic run_one(input logic [AW-1:0] p, input int stall, input string tag);
    int base;
    bit seen;
    logic [7:0] h0, h1, h2;
    @(negedge clk);
    base = acc_total;
    fetch_req = 1'b1; pc = p;
    @(negedge clk);
    fetch_req = 1'b0;
    wait_pkt(seen);
    chk(seen, {tag, " R6 packet arrives"}, seen, 1);
    if (!seen) return;
    check_pkt(p, base, tag);
    h0 = opc; h1 = op1; h2 = op2;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(pkt_valid && opc == h0 && op1 == h1 && op2 == h2, {tag, " R7 hold under stall"},
          {pkt_valid, opc, op1, op2}, {1'b1, h0, h1, h2});
    end
    pkt_ready = 1'b1;
    @(negedge clk);
    pkt_ready = 1'b0;
    chk(!pkt_valid, {tag, " R7 drop after handshake"}, pkt_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);

    repeat (3) @(negedge clk);
    chk(!pkt_valid && !mem_req, "R1 in reset", {pkt_valid, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pkt_valid && !mem_req, "R1 after reset", {pkt_valid, mem_req}, 0);

    // directed boundary cases
    mem[16'h0103 & 1023] = 8'h4C; run_one(16'h0103, 0, "3B last byte");
    mem[16'h0200 & 1023] = 8'hAD; run_one(16'h0200, 1, "3B line start");
    mem[16'h0201 & 1023] = 8'h6D; run_one(16'h0201, 0, "3B ends on line end");
    mem[16'h0302 & 1023] = 8'hA9; run_one(16'h0302, 2, "2B ends on line end");
    mem[16'h0303 & 1023] = 8'h85; run_one(16'h0303, 0, "2B straddle");
    mem[16'h0407 & 1023] = 8'hEA; run_one(16'h0407, 0, "1B last byte");
    mem[16'h0502 & 1023] = 8'h20; run_one(16'h0502, 0, "JSR straddle by one");
    mem[16'hFFFE & 1023] = 8'h2C; run_one(16'hFFFE, 0, "R5 top wrap");
    mem[16'hFFFF & 1023] = 8'hA5; run_one(16'hFFFF, 0, "R5 top wrap 2B");

    // flush while the second half of a straddling fetch is outstanding (R8)
    begin
      int base, base2;
      bit seen;
      mem[16'h0603 & 1023] = 8'h20;
      mem[16'h0710 & 1023] = 8'hA9;
      mem[16'h0711 & 1023] = 8'h5A;
      @(negedge clk);
      base = acc_total;
      fetch_req = 1'b1; pc = 16'h0603;
      @(negedge clk);
      fetch_req = 1'b0;
      for (int i = 0; i < 50 && acc_total == base; i++) @(negedge clk);
      flush = 1'b1; pc = 16'h0710;
      base2 = acc_total;
      @(negedge clk);
      flush = 1'b0;
      wait_pkt(seen);
      chk(seen, "R8 packet after flush", seen, 1);
      if (seen) begin
        chk(opc == 8'hA9 && op1 == 8'h5A && op2 == 8'h00, "R8 flushed packet",
            {opc, op1, op2}, {8'hA9, 8'h5A, 8'h00});
        check_pkt(16'h0710, base2, "R8 restart");
      end
      pkt_ready = 1'b1;
      @(negedge clk);
      pkt_ready = 1'b0;
    end

    // random mix, every fourth fetch forced near a line end
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] p;
      p = AW'($urandom);
      if (n % 4 == 0) p[1:0] = 2'(2 + ($urandom % 2));
      run_one(p, int'($urandom % 4), "random");
    end

    finish_run();
  end
endmodule